// File: doc/BRIEF.md
# Decimal Text Reporter for a Binary Count

This block turns a 30-bit unsigned binary total into one line of readable text on an asynchronous serial output. A producer, such as the accumulator of a frequency counter, presents the total together with a one-cycle valid strobe. The block converts the total to nine decimal digits with a sequential add-3-and-shift converter that takes one input bit per clock. It then formats a fixed-width line and sends it character by character as 8N1 frames.

The line is always 13 characters long. It holds three groups of three digits separated by commas, followed by a carriage return and a line feed. Leading zeros are shown as spaces. A comma that has only blanks to its left is also shown as a space, so the number reads right-aligned.

While a conversion is running, new totals are ignored. A conversion that finishes while a line is still being sent is discarded. The text on the wire therefore always belongs to one whole total.

State machines:

- **Line sequencer.**
  - `L_IDLE` goes to `L_ISSUE` on a conversion-complete pulse and takes a copy of the digits.
  - `L_ISSUE` hands one character to the serializer each time the serializer is free, walking the character index from 0 to 12. After handing over the last character it goes to `L_FLUSH`.
  - `L_FLUSH` returns to `L_IDLE` once the serializer is free again.
- **Serializer.**
  - `S_IDLE` goes to `S_START` when a character is offered.
  - `S_START` goes to `S_DATA` after one bit period.
  - `S_DATA` stays for eight bit periods, then goes to `S_STOP`.
  - `S_STOP` returns to `S_IDLE` after one bit period.

Top module: `count_rpt`

## Requirements
- R1: After reset `txd` is high, and no character is sent until a total has been accepted.
- R2: `total_vld` is accepted only when the converter is idle. A strobe that arrives during a conversion is ignored, and the line reports the earlier total.
- R3: The converter takes the total MSB first, one bit per clock. It adds 3 to any digit above 4 before doubling, and forces a non-BCD digit to zero. Every digit it produces is 0 to 9, and the digits equal the total modulo 10^9, so the tenth decimal digit of totals of 10^9 and above is lost. Completion is a one-cycle pulse.
- R4: Each line is exactly 13 characters, in this order: three digit positions, a separator, three digit positions, a separator, three digit positions, CR (0x0D), LF (0x0A).
- R5: A shown digit is sent as 0x30 plus its value, and digit positions run from the most significant digit to the least.
- R6: Zero digits before the first nonzero digit are sent as a space (0x20). The least significant digit is always shown, so a total of 0 prints as a single `0`.
- R7: A separator is a comma (0x2C) when some digit to its left is shown. Otherwise it is a space (0x20).
- R8: Each character is framed with one low start bit, eight data bits LSB first and one high stop bit. Every bit lasts CLK_HZ/BAUD clock cycles. The line is high between frames.
- R9: A conversion that completes while a line is still in progress is dropped. The line in progress is unchanged, and no further line follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| total_in | input | 30 | Unsigned binary total to report |
| total_vld | input | 1 | One-cycle strobe qualifying `total_in` |
| txd | output | 1 | Serial text output, idles high |

## Verification
The assertions check the following on every cycle:
- the busy register keeps shifting while a conversion runs, whatever happens on the strobe;
- the completion pulse lasts one cycle and carries only BCD digits;
- the line's digit copy stays frozen while the sequencer is busy;
- a character is offered only to an idle serializer, and an idle serializer holds the line high;
- the character index stays within the 13 positions.

The bench's scenarios show what the assertions cannot:
- the decoded text, including blanking, separators and the modulo-10^9 loss for large totals;
- the exact width of every bit;
- that overlapping strobes and late completions never produce an extra line.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    // digits between separators
    localparam int GROUP_LEN = 3;

    localparam logic [7:0] CH_SPACE   = 8'h20;
    localparam logic [7:0] CH_COMMA   = 8'h2C;
    localparam logic [7:0] CH_CR      = 8'h0D;
    localparam logic [7:0] CH_LF      = 8'h0A;
    localparam logic [3:0] CH_DIG_HI  = 4'h3;

    typedef enum logic [1:0] {
        L_IDLE,
        L_ISSUE,
        L_FLUSH
    } line_state_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP
    } ser_state_t;

    // digits + separators + CR + LF
    function automatic int line_len(input int ndig);
        return ndig + (ndig - 1) / GROUP_LEN + 2;
    endfunction

endpackage

// File: rtl/rpt_dd_conv.sv
module rpt_dd_conv #(
    parameter int VAL_W = 30,
    parameter int NDIG  = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [VAL_W-1:0]      value,
    output logic [VAL_W:0]        busy,
    output logic                  done,
    output logic [NDIG-1:0][3:0]  digits
);

    logic [VAL_W-1:0]     work;
    logic [NDIG-1:0][3:0] acc;
    logic [NDIG-1:0][3:0] acc_nx;

    // one add-3-then-double step across all digits, next input bit enters at the bottom
    always_comb begin
        logic       carry;
        logic [3:0] adj;
        carry  = work[VAL_W-1];
        acc_nx = '0;
        for (int k = 0; k < NDIG; k++) begin
            if (acc[k] > 4'd9) begin
                adj = 4'd0;
            end else if (acc[k] > 4'd4) begin
                adj = acc[k] + 4'd3;
            end else begin
                adj = acc[k];
            end
            acc_nx[k] = {adj[2:0], carry};
            carry     = adj[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= '0;
            work   <= '0;
            acc    <= '0;
            done   <= 1'b0;
            digits <= '0;
        end else begin
            done <= 1'b0;
            if (!busy[0]) begin
                if (start) begin
                    busy <= '1;
                    work <= value;
                    acc  <= '0;
                end
            end else begin
                busy <= busy >> 1;
                work <= work << 1;
                acc  <= acc_nx;
                if (!busy[1]) begin
                    digits <= acc;
                    done   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rpt_line_fmt.sv
module rpt_line_fmt
    import rpt_pkg::*;
#(
    parameter  int NDIG  = 9,
    localparam int NCH   = line_len(NDIG),
    localparam int IDX_W = $clog2(NCH)
) (
    input  logic [NDIG-1:0][3:0] digits,
    input  logic [IDX_W-1:0]     idx,
    output logic [7:0]           ch
);

    logic [NDIG-1:0]      shown;
    logic [NCH-1:0][7:0]  text;

    // a digit is shown once any digit at or above it is nonzero; the lowest always is
    always_comb begin
        logic run;
        run   = 1'b0;
        shown = '0;
        for (int j = NDIG - 1; j >= 0; j--) begin
            run      = run | (|digits[j]) | (j == 0);
            shown[j] = run;
        end
    end

    for (genvar k = 0; k < NDIG; k++) begin : g_dig
        localparam int POS = (NDIG - 1 - k) + (NDIG - 1) / GROUP_LEN - k / GROUP_LEN;
        assign text[POS] = shown[k] ? {CH_DIG_HI, digits[k]} : CH_SPACE;
        if (k != 0 && (k % GROUP_LEN) == 0) begin : g_sep
            assign text[POS+1] = shown[k] ? CH_COMMA : CH_SPACE;
        end
    end

    assign text[NCH-2] = CH_CR;
    assign text[NCH-1] = CH_LF;

    assign ch = (idx < IDX_W'(NCH)) ? text[idx] : CH_SPACE;

endmodule

// File: rtl/rpt_uart_ser.sv
module rpt_uart_ser
    import rpt_pkg::*;
#(
    parameter int CLKS_PER_BIT = 1666
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] byte_in,
    input  logic       byte_vld,
    output logic       ready,
    output logic       txd
);

    localparam int            CW       = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);

    ser_state_t    st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [2:0]    bitn, bitn_nx;
    logic [7:0]    sh, sh_nx;
    logic          tick;

    assign tick  = (cnt == CNT_LAST);
    assign ready = (st == S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        cnt_nx  = cnt;
        bitn_nx = bitn;
        sh_nx   = sh;
        unique case (st)
            S_IDLE: begin
                if (byte_vld) begin
                    st_nx  = S_START;
                    cnt_nx = '0;
                    sh_nx  = byte_in;
                end
            end
            S_START: begin
                if (tick) begin
                    st_nx   = S_DATA;
                    cnt_nx  = '0;
                    bitn_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            S_DATA: begin
                if (tick) begin
                    cnt_nx = '0;
                    sh_nx  = {1'b0, sh[7:1]};
                    if (bitn == 3'd7) begin
                        st_nx = S_STOP;
                    end else begin
                        bitn_nx = bitn + 1'b1;
                    end
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            S_STOP: begin
                if (tick) begin
                    st_nx  = S_IDLE;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
        endcase
    end

    // registered line level follows the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            txd  <= 1'b1;
        end else begin
            cnt  <= cnt_nx;
            bitn <= bitn_nx;
            sh   <= sh_nx;
            unique case (st_nx)
                S_START: txd <= 1'b0;
                S_DATA:  txd <= sh_nx[0];
                S_IDLE,
                S_STOP:  txd <= 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/count_rpt.sv
module count_rpt
    import rpt_pkg::*;
#(
    parameter int VAL_W  = 30,
    parameter int NDIG   = 9,
    parameter int CLK_HZ = 32000000,
    parameter int BAUD   = 19200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] total_in,
    input  logic             total_vld,
    output logic             txd
);

    localparam int CLKS_PER_BIT = CLK_HZ / BAUD;
    localparam int NCH          = line_len(NDIG);
    localparam int IDX_W        = $clog2(NCH);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NCH - 1);

    logic [VAL_W:0]       conv_busy;
    logic                 conv_done;
    logic [NDIG-1:0][3:0] conv_digits;
    logic [NDIG-1:0][3:0] line_digits;
    logic [IDX_W-1:0]     char_idx;
    logic [7:0]           cur_char;
    logic                 ser_ready;
    logic                 byte_vld;
    line_state_t          ln_st, ln_nx;

    rpt_dd_conv #(
        .VAL_W (VAL_W),
        .NDIG  (NDIG)
    ) u_conv (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (total_vld),
        .value  (total_in),
        .busy   (conv_busy),
        .done   (conv_done),
        .digits (conv_digits)
    );

    rpt_line_fmt #(
        .NDIG (NDIG)
    ) u_fmt (
        .digits (line_digits),
        .idx    (char_idx),
        .ch     (cur_char)
    );

    rpt_uart_ser #(
        .CLKS_PER_BIT (CLKS_PER_BIT)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (cur_char),
        .byte_vld (byte_vld),
        .ready    (ser_ready),
        .txd      (txd)
    );

    // line sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_st <= L_IDLE;
        end else begin
            ln_st <= ln_nx;
        end
    end

    always_comb begin
        ln_nx = ln_st;
        unique case (ln_st)
            L_IDLE: begin
                if (conv_done) begin
                    ln_nx = L_ISSUE;
                end
            end
            L_ISSUE: begin
                if (ser_ready && char_idx == IDX_LAST) begin
                    ln_nx = L_FLUSH;
                end
            end
            L_FLUSH: begin
                if (ser_ready) begin
                    ln_nx = L_IDLE;
                end
            end
            default: ln_nx = L_IDLE;
        endcase
    end

    assign byte_vld = (ln_st == L_ISSUE) && ser_ready;

    // line sequencer: outputs (digit copy and character index)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_digits <= '0;
            char_idx    <= '0;
        end else begin
            unique case (ln_st)
                L_IDLE: begin
                    if (conv_done) begin
                        line_digits <= conv_digits;
                        char_idx    <= '0;
                    end
                end
                L_ISSUE: begin
                    if (ser_ready && char_idx != IDX_LAST) begin
                        char_idx <= char_idx + 1'b1;
                    end
                end
                L_FLUSH: begin
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/count_rpt_chk.sv
module count_rpt_chk
    import rpt_pkg::*;
#(
    parameter  int VAL_W = 30,
    parameter  int NDIG  = 9,
    localparam int NCH   = line_len(NDIG),
    localparam int IDX_W = $clog2(NCH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 txd,
    input logic [VAL_W:0]       conv_busy,
    input logic                 conv_done,
    input logic [NDIG-1:0][3:0] conv_digits,
    input logic [NDIG-1:0][3:0] line_digits,
    input logic [IDX_W-1:0]     char_idx,
    input logic                 ser_ready,
    input logic                 byte_vld,
    input line_state_t          ln_st
);

    logic dig_ok;
    always_comb begin
        dig_ok = 1'b1;
        for (int k = 0; k < NDIG; k++) begin
            if (conv_digits[k] > 4'd9) begin
                dig_ok = 1'b0;
            end
        end
    end

    // R2: once running, the busy register only shifts, a strobe cannot restart it
    assert_busy_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy[0] |=> (conv_busy == ($past(conv_busy) >> 1)));

    // R3: completion is a single-cycle pulse
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    // R3: completed digits are all BCD
    assert_bcd_digits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> dig_ok);

    // R4: character index never leaves the line
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        char_idx < IDX_W'(NCH));

    // R8: idle serializer keeps the line high
    assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_ready |-> txd);

    // R8: a character is only offered to an idle serializer
    assert_offer_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> ser_ready);

    // R9: the line copy is frozen while a line is in progress
    assert_line_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_st != L_IDLE) |=> $stable(line_digits));

endmodule

bind count_rpt count_rpt_chk #(
    .VAL_W (VAL_W),
    .NDIG  (NDIG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .txd         (txd),
    .conv_busy   (conv_busy),
    .conv_done   (conv_done),
    .conv_digits (conv_digits),
    .line_digits (line_digits),
    .char_idx    (char_idx),
    .ser_ready   (ser_ready),
    .byte_vld    (byte_vld),
    .ln_st       (ln_st)
);

// File: tb/count_rpt_test.sv
module count_rpt_test;

    localparam int CLK_PERIOD = 10;
    localparam int VAL_W      = 30;
    localparam int BAUD       = 19200;
    localparam int CPB        = 4;
    localparam int FRAME      = 10 * CPB;
    localparam int LINE_N     = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [VAL_W-1:0] total_in = '0;
    logic             total_vld = 1'b0;
    logic             txd;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    logic [7:0] rx_buf [0:2047];
    int         rx_wr = 0;
    int         rx_rd = 0;
    logic [FRAME-1:0] smp;
    logic [7:0]  exp_line [0:LINE_N-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    count_rpt #(
        .VAL_W  (VAL_W),
        .NDIG   (9),
        .CLK_HZ (BAUD * CPB),
        .BAUD   (BAUD)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .total_in  (total_in),
        .total_vld (total_vld),
        .txd       (txd)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cyc);
            finish_run();
        end
    end

    // behavioural receiver: one sample per falling clock edge, R8 framing checked per frame
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                logic [7:0] b;
                bit         frame_ok;
                smp[0] = 1'b0;
                for (int i = 1; i < FRAME; i++) begin
                    @(negedge clk);
                    smp[i] = txd;
                end
                frame_ok = 1;
                for (int bt = 0; bt < 10; bt++) begin
                    for (int s = 1; s < CPB; s++) begin
                        if (smp[bt*CPB+s] !== smp[bt*CPB]) frame_ok = 0;
                    end
                end
                for (int bt = 0; bt < 8; bt++) b[bt] = smp[(bt+1)*CPB + CPB/2];
                if (smp[CPB/2] !== 1'b0) frame_ok = 0;
                if (smp[9*CPB + CPB/2] !== 1'b1) frame_ok = 0;
                checks++;
                if (!frame_ok) begin
                    fails++;
                    $display("FAIL R8 frame: actual samples=%b expected start low, 8 stable bits, stop high", smp);
                end
                rx_buf[rx_wr % 2048] = b;
                rx_wr++;
            end
        end
    end

    task automatic send_total(input logic [VAL_W-1:0] v);
        @(negedge clk);
        total_in  = v;
        total_vld = 1'b1;
        @(negedge clk);
        total_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic build_expected(input longint v);
        int     d [0:8];
        longint r;
        bit     seen;
        int     p;
        r = v % 1000000000;
        for (int k = 0; k < 9; k++) begin
            d[k] = int'(r % 10);
            r    = r / 10;
        end
        seen = 0;
        p    = 0;
        for (int k = 8; k >= 0; k--) begin
            if (d[k] != 0 || k == 0) seen = 1;
            exp_line[p] = seen ? 8'(8'h30 + d[k]) : 8'h20;
            p++;
            if (k == 6 || k == 3) begin
                exp_line[p] = seen ? 8'h2C : 8'h20;
                p++;
            end
        end
        exp_line[11] = 8'h0D;
        exp_line[12] = 8'h0A;
    endtask

    task automatic expect_line(input longint v, input string req);
        int  waited;
        bit  ok;
        int  bad_pos;
        build_expected(v);
        waited = 0;
        while (rx_wr < rx_rd + LINE_N && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        checks++;
        if (rx_wr < rx_rd + LINE_N) begin
            fails++;
            $display("FAIL %s line for %0d: actual %0d chars expected %0d", req, v, rx_wr - rx_rd, LINE_N);
            rx_rd = rx_wr;
            return;
        end
        ok = 1;
        bad_pos = 0;
        for (int i = LINE_N - 1; i >= 0; i--) begin
            if (rx_buf[(rx_rd + i) % 2048] !== exp_line[i]) begin
                ok = 0;
                bad_pos = i;
            end
        end
        if (!ok) begin
            fails++;
            $display("FAIL %s line for %0d at char %0d: actual 0x%02h expected 0x%02h",
                     req, v, bad_pos, rx_buf[(rx_rd + bad_pos) % 2048], exp_line[bad_pos]);
        end
        rx_rd += LINE_N;
        idle(8);
    endtask

    task automatic expect_silence(input int n, input string req);
        bit stayed_high;
        stayed_high = 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed_high = 0;
        end
        checks++;
        if (!stayed_high || rx_wr != rx_rd) begin
            fails++;
            $display("FAIL %s silence: actual extra chars=%0d high=%0b expected 0 and 1",
                     req, rx_wr - rx_rd, stayed_high);
        end
    endtask

    initial begin
        longint pw;
        logic [31:0] lcg;

        idle(5);
        checks++;
        if (txd !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset: actual txd=%b expected 1", txd);
        end
        rst_n = 1'b1;
        expect_silence(200, "R1");

        // R6 R7 R5 R4: small values show blanks and blank separators
        send_total(30'd0);          expect_line(0, "R6");
        send_total(30'd7);          expect_line(7, "R6");
        send_total(30'd999);        expect_line(999, "R7");
        send_total(30'd1000);       expect_line(1000, "R7");
        send_total(30'd123456789);  expect_line(123456789, "R5");
        send_total(30'd100000001);  expect_line(100000001, "R4");

        // R3: powers of ten and the value just below each
        pw = 1;
        for (int k = 0; k <= 9; k++) begin
            send_total(VAL_W'(pw));     expect_line(pw, "R3");
            send_total(VAL_W'(pw - 1)); expect_line(pw - 1, "R3");
            pw = pw * 10;
        end

        // R3: 30-bit maximum, tenth digit lost
        send_total('1); expect_line(longint'(1073741823), "R3");

        // R3 R5: spread of magnitudes
        lcg = 32'h1234_5678;
        for (int i = 0; i < 24; i++) begin
            logic [VAL_W-1:0] v;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            v   = lcg[VAL_W-1:0] >> (i % 28);
            send_total(v);
            expect_line(longint'(v), "R3");
        end

        // R2: second strobe during conversion is ignored
        send_total(30'd42);
        idle(4);
        send_total(30'd777);
        expect_line(42, "R2");
        expect_silence(700, "R2");

        // R9: conversion completing during a line is dropped
        send_total(30'd987654321);
        idle(80);
        send_total(30'd555);
        expect_line(987654321, "R9");
        expect_silence(700, "R9");

        // recovery after a dropped total
        send_total(30'd31415926);
        expect_line(31415926, "R9");

        finish_run();
    end

endmodule